// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two eight-bit bidirectional buses, side A and side B. Each direction has its own storage word. The A-to-B word is loaded from the A bus, and the B-to-A word is loaded from the B bus. Each direction has a source select, which puts either the live opposite bus or that direction's stored word onto its output. Each direction also has an output enable. The A-to-B enable is active high and the B-to-A enable is active low.

Each bus pin is split into four signals so that the block stays synthesizable: an incoming value, an external-driver-present flag, an outgoing value and a drive enable. An optional keeper per side remembers the last resolved value of a bus while nobody drives it. The keeper also breaks the feedback loop that appears when both directions pass live data at once.

Everything runs on one system clock. Each direction is loaded by a capture strobe that is synchronous to that clock. The word loads on the first clock edge at which the strobe is seen high after being low. Using these controls, the block can isolate the buses, store from either side, pass data through live, replay stored words, or swap the two stored words across the buses in one step.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst` is high, `a_oe` and `b_oe` are low. A clock edge with `rst` high clears both stored words and both keepers to zero.
- R2: On the first clock edge where `stb_a2b` is sampled high after being sampled low on the previous edge, the A-to-B word loads the resolved A bus value. The select and enable inputs do not affect this. The resolved value is `a_in` when `a_in_drv` is 1; otherwise it is `a_out` when `a_oe` is 1; otherwise it is the A keeper.
- R3: The B-to-A word loads the resolved B bus value in the same way, under `stb_b2a`.
- R4: A stored word does not change on an edge where its strobe is low, or where its strobe was already high on the previous edge.
- R5: `b_oe` equals `en_a2b` (active high). `a_oe` equals the inverse of `en_b2a_n` (active low).
- R6: With `sel_a2b` = 0, `b_out` is the value seen on A in the same cycle, with no register stage. That value is `a_in` when driven externally, else the A keeper. With `sel_a2b` = 1, `b_out` is the A-to-B word.
- R7: With `sel_b2a` = 0, `a_out` is the value seen on B in the same cycle. With `sel_b2a` = 1, `a_out` is the B-to-A word.
- R8: With `en_a2b` = 0 and `en_b2a_n` = 1, neither side is driven, and both words still load from their own buses.
- R9: With both enables active and both selects at 1, `b_out` shows the A-to-B word and `a_out` shows the B-to-A word in the same cycle.
- R10: A bus with no external driver, and not driven by the block, presents its last resolved value from the keeper to the live path and to the capture logic.
- R11: With both enables active and both selects at 0, a value driven externally onto one bus is held on both buses after that driver releases. No combinational loop is formed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 8 | Value present on the A bus from outside |
| a_in_drv | input | 1 | An external source drives the A bus |
| a_out | output | 8 | Value the block drives onto the A bus |
| a_oe | output | 1 | Block drives the A bus |
| b_in | input | 8 | Value present on the B bus from outside |
| b_in_drv | input | 1 | An external source drives the B bus |
| b_out | output | 8 | Value the block drives onto the B bus |
| b_oe | output | 1 | Block drives the B bus |
| stb_a2b | input | 1 | Capture strobe for the A-to-B word |
| stb_b2a | input | 1 | Capture strobe for the B-to-A word |
| sel_a2b | input | 1 | B output source: 0 live A, 1 stored word |
| sel_b2a | input | 1 | A output source: 0 live B, 1 stored word |
| en_a2b | input | 1 | Drive enable for B, active high |
| en_b2a_n | input | 1 | Drive enable for A, active low |

## Verification
The bench changes the source bus and checks the opposite output within the same cycle. A design with a stray pipeline stage on the live path would show the old word there.

The bench also holds a strobe high across several edges while the bus changes. A level-sensitive load would overwrite the word, and a directed swap then exposes it.

The loop case drives B, releases it and expects both buses to keep the word. A design without the keeper, or with a keeper that samples its own looped output, would drop the value or swap the two sides every cycle.

Finally, the bench stores A into both words through the live B path. This shows that the B-to-A word captures the resolved bus rather than only the external input.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic {
    SRC_LIVE = 1'b0,
    SRC_HELD = 1'b1
  } src_sel_e;
endpackage

// File: rtl/bt_store_reg.sv
module bt_store_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stb,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic stb_q;

  // strobe history is tracked in reset too, so a level held through reset is not a rise
  always_ff @(posedge clk) begin
    stb_q <= stb;
    if (rst)                q <= '0;
    else if (stb && !stb_q) q <= d;
  end

  // R2, R3
  load_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stb) |=> (q == $past(d)));

  // R4
  hold_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(stb) |=> $stable(q));
endmodule

// File: rtl/bt_keeper.sv
module bt_keeper #(
  parameter int W       = 8,
  parameter bit KEEP_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ext_drv,
  input  logic [W-1:0] ext_val,
  input  logic [W-1:0] bus_val,
  input  logic         hold,
  output logic [W-1:0] seen
);
  generate
    if (KEEP_EN) begin : g_keep
      logic [W-1:0] kq;
      always_ff @(posedge clk) begin
        if (rst)        kq <= '0;
        else if (!hold) kq <= bus_val;
      end
      assign seen = ext_drv ? ext_val : kq;
    end else begin : g_pass
      assign seen = ext_val;
    end
  endgenerate
endmodule

// File: rtl/bt_dir_path.sv
module bt_dir_path
  import bt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         rst,
  input  logic         en,
  input  src_sel_e     sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  output logic [W-1:0] drv,
  output logic         oe
);
  always_comb begin
    drv = (sel == SRC_HELD) ? held : live;
    oe  = en && !rst;
  end
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import bt_pkg::*;
#(
  parameter int W       = 8,
  parameter bit KEEP_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic         a_in_drv,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  input  logic         b_in_drv,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         stb_a2b,
  input  logic         stb_b2a,
  input  logic         sel_a2b,
  input  logic         sel_b2a,
  input  logic         en_a2b,
  input  logic         en_b2a_n
);
  src_sel_e     sel_ab, sel_ba;
  logic [W-1:0] a_seen, b_seen, a_bus, b_bus, ab_q, ba_q;
  logic         a_hold, b_hold;

  assign sel_ab = src_sel_e'(sel_a2b);
  assign sel_ba = src_sel_e'(sel_b2a);

  // resolved bus: external wins, then own drive, then keeper
  assign a_bus = (!a_in_drv && a_oe) ? a_out : a_seen;
  assign b_bus = (!b_in_drv && b_oe) ? b_out : b_seen;

  // keeper must not learn a value that only loops back from the other keeper
  assign a_hold = a_oe && (sel_ba == SRC_LIVE) && !a_in_drv && !b_in_drv;
  assign b_hold = b_oe && (sel_ab == SRC_LIVE) && !b_in_drv && !a_in_drv;

  bt_keeper #(.W(W), .KEEP_EN(KEEP_EN)) keep_a_i (
    .clk(clk), .rst(rst), .ext_drv(a_in_drv), .ext_val(a_in),
    .bus_val(a_bus), .hold(a_hold), .seen(a_seen));

  bt_keeper #(.W(W), .KEEP_EN(KEEP_EN)) keep_b_i (
    .clk(clk), .rst(rst), .ext_drv(b_in_drv), .ext_val(b_in),
    .bus_val(b_bus), .hold(b_hold), .seen(b_seen));

  bt_store_reg #(.W(W)) reg_ab_i (
    .clk(clk), .rst(rst), .stb(stb_a2b), .d(a_bus), .q(ab_q));

  bt_store_reg #(.W(W)) reg_ba_i (
    .clk(clk), .rst(rst), .stb(stb_b2a), .d(b_bus), .q(ba_q));

  bt_dir_path #(.W(W)) path_ab_i (
    .rst(rst), .en(en_a2b), .sel(sel_ab), .live(a_seen), .held(ab_q),
    .drv(b_out), .oe(b_oe));

  bt_dir_path #(.W(W)) path_ba_i (
    .rst(rst), .en(!en_b2a_n), .sel(sel_ba), .live(b_seen), .held(ba_q),
    .drv(a_out), .oe(a_oe));

  // R6
  b_live_chk: assert property (@(posedge clk) disable iff (rst)
    (en_a2b && !sel_a2b && a_in_drv) |-> (b_oe && b_out == a_in));

  // R7
  a_live_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_b2a_n && !sel_b2a && b_in_drv) |-> (a_oe && a_out == b_in));

  // R9
  swap_chk: assert property (@(posedge clk) disable iff (rst)
    (en_a2b && !en_b2a_n && sel_a2b && sel_b2a) |-> (b_out == ab_q && a_out == ba_q));

  // R8
  isolate_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_a2b && en_b2a_n) |-> (!a_oe && !b_oe));

  // R11
  loop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en_a2b && !en_b2a_n && !sel_a2b && !sel_b2a && !a_in_drv && !b_in_drv &&
     $past(en_a2b && !en_b2a_n && !sel_a2b && !sel_b2a && !a_in_drv && !b_in_drv))
    |-> ($stable(a_out) && $stable(b_out)));
endmodule

// File: tb/regbus_xcvr_tb_top.sv
module regbus_xcvr_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst, a_in_drv, b_in_drv, stb_a2b, stb_b2a, sel_a2b, sel_b2a, en_a2b, en_b2a_n;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_oe, b_oe;

  // staged stimulus, copied to the pins at the falling edge
  logic         s_rst = 1'b1, s_adrv = 1'b0, s_bdrv = 1'b0, s_sab = 1'b0, s_sba = 1'b0;
  logic         s_selab = 1'b0, s_selba = 1'b0, s_enab = 1'b0, s_enba_n = 1'b1;
  logic [W-1:0] s_a = '0, s_b = '0;

  // reference state
  logic [W-1:0] m_ab = '0, m_ba = '0, m_ka = '0, m_kb = '0;
  logic         m_pa = 1'b0, m_pb = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  initial begin
    rst = 1'b1; a_in = '0; b_in = '0; a_in_drv = 1'b0; b_in_drv = 1'b0;
    stb_a2b = 1'b0; stb_b2a = 1'b0; sel_a2b = 1'b0; sel_b2a = 1'b0;
    en_a2b = 1'b0; en_b2a_n = 1'b1;
  end

  regbus_xcvr #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .a_in_drv(a_in_drv), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_in_drv(b_in_drv), .b_out(b_out), .b_oe(b_oe),
    .stb_a2b(stb_a2b), .stb_b2a(stb_b2a), .sel_a2b(sel_a2b), .sel_b2a(sel_b2a),
    .en_a2b(en_a2b), .en_b2a_n(en_b2a_n));

  function automatic string mode_tag();
    if (s_rst)                                   return "R1";
    if (!s_enab && s_enba_n)                     return "R8";
    if (s_enab && !s_enba_n && s_selab && s_selba)   return "R9";
    if (s_enab && !s_enba_n && !s_selab && !s_selba) return "R11";
    if (s_enab)                                  return "R6";
    return "R7";
  endfunction

  task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    logic [W-1:0] sa, sb, eao, ebo, abus, bbus;
    logic         eaoe, eboe, ha, hb;
    @(negedge clk);
    rst = s_rst; a_in = s_a; b_in = s_b; a_in_drv = s_adrv; b_in_drv = s_bdrv;
    stb_a2b = s_sab; stb_b2a = s_sba; sel_a2b = s_selab; sel_b2a = s_selba;
    en_a2b = s_enab; en_b2a_n = s_enba_n;
    #1;
    sa   = s_adrv ? s_a : m_ka;
    sb   = s_bdrv ? s_b : m_kb;
    eboe = !s_rst && s_enab;
    eaoe = !s_rst && !s_enba_n;
    ebo  = s_selab ? m_ab : sa;
    eao  = s_selba ? m_ba : sb;
    abus = (!s_adrv && eaoe) ? eao : sa;
    bbus = (!s_bdrv && eboe) ? ebo : sb;
    chk(s_rst ? "R1" : "R5", "b_oe", W'(b_oe), W'(eboe));
    chk(s_rst ? "R1" : "R5", "a_oe", W'(a_oe), W'(eaoe));
    if (eboe) chk(tag, "b_out", b_out, ebo);
    if (eaoe) chk(tag, "a_out", a_out, eao);
    ha = eaoe && !s_selba && !s_adrv && !s_bdrv;
    hb = eboe && !s_selab && !s_bdrv && !s_adrv;
    if (s_rst) begin
      m_ab = '0; m_ba = '0; m_ka = '0; m_kb = '0;
    end else begin
      if (s_sab && !m_pa) m_ab = abus;
      if (s_sba && !m_pb) m_ba = bbus;
      if (!ha) m_ka = abus;
      if (!hb) m_kb = bbus;
    end
    m_pa = s_sab; m_pb = s_sba;
  endtask

  task automatic set_mode(input logic enab, input logic enba_n, input logic selab, input logic selba);
    s_enab = enab; s_enba_n = enba_n; s_selab = selab; s_selba = selba;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1652;
    void'($urandom(seed));
    // R1: reset state, no drive even with enables active
    s_rst = 1'b1; set_mode(1'b1, 1'b0, 1'b1, 1'b1);
    repeat (3) step("R1");
    s_rst = 1'b0;
    // R8: isolation, both words load from their buses (R2, R3)
    set_mode(1'b0, 1'b1, 1'b0, 1'b0);
    s_a = 8'h5A; s_adrv = 1'b1; s_b = 8'hC3; s_bdrv = 1'b1;
    step("R8");
    s_sab = 1'b1; s_sba = 1'b1; step("R8");
    // R4: strobes stay high while buses change: no new load
    s_a = 8'h11; s_b = 8'h22; repeat (3) step("R4");
    s_sab = 1'b0; s_sba = 1'b0; step("R4");
    // R9: swap of stored words, expect 5A on B and C3 on A
    s_adrv = 1'b0; s_bdrv = 1'b0; set_mode(1'b1, 1'b0, 1'b1, 1'b1);
    repeat (2) step("R9");
    // R3: store A in both words through the live B path
    set_mode(1'b1, 1'b1, 1'b0, 1'b0); s_a = 8'h77; s_adrv = 1'b1;
    step("R6");
    s_sab = 1'b1; s_sba = 1'b1; step("R3");
    s_sab = 1'b0; s_sba = 1'b0; s_adrv = 1'b0;
    set_mode(1'b1, 1'b0, 1'b1, 1'b1); step("R3");
    // R6: live A to B in the same cycle
    set_mode(1'b1, 1'b1, 1'b0, 1'b0); s_adrv = 1'b1;
    for (int i = 0; i < 4; i++) begin s_a = 8'h0F << i; step("R6"); end
    // R7: live B to A, then stored B word
    set_mode(1'b0, 1'b0, 1'b0, 1'b0); s_adrv = 1'b0; s_bdrv = 1'b1;
    for (int i = 0; i < 4; i++) begin s_b = 8'hF0 >> i; step("R7"); end
    s_selba = 1'b1; step("R7");
    // R10: keeper on A after its driver leaves
    set_mode(1'b0, 1'b1, 1'b0, 1'b0); s_a = 8'h3C; s_adrv = 1'b1; s_bdrv = 1'b0; step("R10");
    s_adrv = 1'b0; s_a = 8'hFF; step("R10");
    set_mode(1'b1, 1'b1, 1'b0, 1'b0); repeat (2) step("R10");
    // R11: loop mode, drive B, then release it
    set_mode(1'b1, 1'b0, 1'b0, 1'b0); s_b = 8'h96; s_bdrv = 1'b1; step("R11");
    s_bdrv = 1'b0; s_b = 8'h00; repeat (4) step("R11");
    // random mix
    for (int i = 0; i < 600; i++) begin
      s_rst    = ($urandom % 50) == 0;
      s_a      = W'($urandom); s_b = W'($urandom);
      s_adrv   = $urandom % 2; s_bdrv = $urandom % 2;
      s_sab    = $urandom % 2; s_sba  = $urandom % 2;
      set_mode($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
      step(mode_tag());
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule